// File: doc/BRIEF.md
# Latched Serial Command Register Interface

This block takes 24-bit commands from a three-wire serial host: a serial clock, a data line and a separate latch strobe. Bits enter a shift register MSB first on each rising serial-clock edge, and shifting continues whatever the latch level. A rising latch edge commits the 24 most recent bits. The top byte of the word selects the operation and the low 16 bits are its operand. A commit can write the data register, write the control register, clear both registers, arm a readback, or do nothing.

All three serial inputs pass through two-flop synchronizers into a system clock that runs at least four times faster than the serial clock. Edges are detected in that domain. A frame whose serial-clock edge count is wrong is dropped, and a one-cycle error pulse marks it. When bit 3 of the control register is set, the part runs in chain mode. In chain mode, bits pushed past the 24th leave on the serial output, so one bus of 24 x N clocks can serve N parts.

Top module: `serial_cmd_if`

## Requirements
- R1: After reset, `data_o` and `ctrl_o` are zero, `sdo_o` is low, and neither `wr_stb_o` nor `frame_err_o` pulses.
- R2: A frame of exactly 24 rising serial-clock edges is taken MSB first. If its byte (bits 23:16) is 0x01, its bits 15:0 are committed to `data_o` on the latch rise, and `wr_stb_o` pulses for one cycle.
- R3: Byte 0x55 writes bits 15:0 to `ctrl_o` and pulses `wr_stb_o` once. Control bit 3 enables chain mode.
- R4: Outside chain mode, a frame with fewer or more than 24 rising edges updates no register and gives no `wr_stb_o`. It gives a single one-cycle `frame_err_o` pulse instead.
- R5: Serial bits keep shifting while the latch is high. Only a rising latch edge commits, and it commits the last 24 bits clocked in.
- R6: Byte 0x00, and any byte not listed in R2, R3, R7 and R8, changes no register and gives neither a strobe nor an error.
- R7: Byte 0x56 with bit 0 set clears `data_o` and `ctrl_o` and pulses `wr_stb_o`. With bit 0 clear it has no effect.
- R8: Byte 0x02 arms a readback. Bits 1:0 select the source: 0 gives the status word (bit 0 is a sticky frame-error flag since reset), 1 gives data, 2 gives control, 3 gives zero. The output word is {6'b0, select, value}. It leaves MSB first on `sdo_o` during the next frame, and `sdo_o` changes only after falling serial-clock edges. The next latch rise disarms the readback. While neither a readback is armed nor chain mode is on, `sdo_o` is low.
- R9: In chain mode, a frame is accepted when it has at least 24 rising edges. The latch commits the last 24 bits, and the bits shifted beyond the 24th appear on `sdo_o` in order. A frame of fewer than 24 edges still raises `frame_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data, sampled on rising serial-clock edges |
| latch_i | input | 1 | Commit strobe, acts on its rising edge |
| sdo_o | output | 1 | Serial output for readback or chain mode |
| data_o | output | 16 | Data register |
| ctrl_o | output | 16 | Control register |
| wr_stb_o | output | 1 | One-cycle pulse on each register update |
| frame_err_o | output | 1 | One-cycle pulse on a rejected frame |

## Verification
Some properties are checked by assertions on every cycle. Strobe and error pulses last a single cycle, and the two never coincide. The data register never changes without a strobe. A clear command zeroes both registers. After every falling serial-clock edge, the output bit follows the shift register's top bit. Other behaviour can only be shown by the bench's scenarios: MSB-first assembly, acceptance that depends on the edge count, commit only on the latch edge while shifting goes on, the exact bit order of readback words, and which bits ripple through in chain mode.

// File: rtl/scif_pkg.sv
package scif_pkg;
  parameter int unsigned FRAME_W   = 24;
  parameter int unsigned DATA_W    = 16;
  parameter int unsigned CHAIN_BIT = 3;

  typedef enum logic [7:0] {
    OP_NOP  = 8'h00,
    OP_DATA = 8'h01,
    OP_RDBK = 8'h02,
    OP_CTRL = 8'h55,
    OP_CLR  = 8'h56
  } op_e;

  typedef enum logic [1:0] {
    RB_STAT = 2'd0,
    RB_DATA = 2'd1,
    RB_CTRL = 2'd2,
    RB_ZERO = 2'd3
  } rb_sel_e;
endpackage

// File: rtl/scif_sync.sv
module scif_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [STAGES-1:0][N-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/scif_shifter.sv
module scif_shifter #(
  parameter int unsigned FRAME_W = 24,
  parameter int unsigned CNT_W   = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_rise_i,
  input  logic               sclk_fall_i,
  input  logic               sdi_i,
  input  logic               latch_rise_i,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] load_word_i,
  output logic [FRAME_W-1:0] word_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               sdo_o
);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_W + 1);

  logic [FRAME_W-1:0] shreg_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               sdo_q;

  // edge counter restarts on each latch rise, saturates one past a full frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cnt_q <= '0;
    else if (latch_rise_i)                 cnt_q <= sclk_rise_i ? CNT_W'(1) : '0;
    else if (sclk_rise_i && cnt_q != CNT_SAT) cnt_q <= cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          shreg_q <= '0;
    else if (load_i)      shreg_q <= load_word_i;
    else if (sclk_rise_i) shreg_q <= {shreg_q[FRAME_W-2:0], sdi_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          sdo_q <= 1'b0;
    else if (load_i)      sdo_q <= load_word_i[FRAME_W-1];
    else if (sclk_fall_i) sdo_q <= shreg_q[FRAME_W-1];
  end

  assign word_o = shreg_q;
  assign cnt_o  = cnt_q;
  assign sdo_o  = sdo_q;

  a_r9_sdo_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_fall_i && !load_i |=> sdo_q == $past(shreg_q[FRAME_W-1]));
endmodule

// File: rtl/scif_regs.sv
module scif_regs
  import scif_pkg::*;
#(
  parameter int unsigned FRAME_W = 24,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned CNT_W   = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               latch_rise_i,
  input  logic [FRAME_W-1:0] word_i,
  input  logic [CNT_W-1:0]   cnt_i,
  output logic [DATA_W-1:0]  data_o,
  output logic [DATA_W-1:0]  ctrl_o,
  output logic               wr_stb_o,
  output logic               err_o,
  output logic               chain_o,
  output logic               rb_pend_o,
  output logic               load_o,
  output logic [FRAME_W-1:0] load_word_o
);
  localparam int unsigned PAD_W = FRAME_W - DATA_W - 2;

  logic [DATA_W-1:0] data_q, ctrl_q, rb_val;
  logic              stb_q, err_q, err_seen_q, rb_pend_q, load_q;
  logic [FRAME_W-1:0] load_word_q;
  logic [FRAME_W-DATA_W-1:0] op;
  logic [DATA_W-1:0] arg;
  logic              chain, frame_ok;

  assign op    = word_i[FRAME_W-1:DATA_W];
  assign arg   = word_i[DATA_W-1:0];
  assign chain = ctrl_q[CHAIN_BIT];
  assign frame_ok = chain ? (cnt_i >= CNT_W'(FRAME_W)) : (cnt_i == CNT_W'(FRAME_W));

  always_comb begin
    case (rb_sel_e'(arg[1:0]))
      RB_STAT: rb_val = {{(DATA_W-1){1'b0}}, err_seen_q};
      RB_DATA: rb_val = data_q;
      RB_CTRL: rb_val = ctrl_q;
      default: rb_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q      <= '0;
      ctrl_q      <= '0;
      stb_q       <= 1'b0;
      err_q       <= 1'b0;
      err_seen_q  <= 1'b0;
      rb_pend_q   <= 1'b0;
      load_q      <= 1'b0;
      load_word_q <= '0;
    end else begin
      stb_q  <= 1'b0;
      err_q  <= 1'b0;
      load_q <= 1'b0;
      if (latch_rise_i) begin
        rb_pend_q <= 1'b0;
        if (!frame_ok) begin
          err_q      <= 1'b1;
          err_seen_q <= 1'b1;
        end else begin
          case (op_e'(op))
            OP_DATA: begin data_q <= arg; stb_q <= 1'b1; end
            OP_CTRL: begin ctrl_q <= arg; stb_q <= 1'b1; end
            OP_CLR: if (arg[0]) begin
              data_q <= '0;
              ctrl_q <= '0;
              stb_q  <= 1'b1;
            end
            OP_RDBK: begin
              load_q      <= 1'b1;
              load_word_q <= {{PAD_W{1'b0}}, arg[1:0], rb_val};
              rb_pend_q   <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign data_o      = data_q;
  assign ctrl_o      = ctrl_q;
  assign wr_stb_o    = stb_q;
  assign err_o       = err_q;
  assign chain_o     = chain;
  assign rb_pend_o   = rb_pend_q;
  assign load_o      = load_q;
  assign load_word_o = load_word_q;

  a_r4_err_no_stb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> !stb_q);
  a_r4_err_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> !err_q);
  a_r2_stb_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |=> !stb_q);
  a_r2_data_needs_stb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_q) |-> stb_q);
  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_rise_i && frame_ok && op == OP_CLR && arg[0] |=> data_q == '0 && ctrl_q == '0);
endmodule

// File: rtl/serial_cmd_if.sv
module serial_cmd_if
  import scif_pkg::*;
#(
  parameter int unsigned FRAME_BITS  = scif_pkg::FRAME_W,
  parameter int unsigned WORD_BITS   = scif_pkg::DATA_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sclk_i,
  input  logic                 sdi_i,
  input  logic                 latch_i,
  output logic                 sdo_o,
  output logic [WORD_BITS-1:0] data_o,
  output logic [WORD_BITS-1:0] ctrl_o,
  output logic                 wr_stb_o,
  output logic                 frame_err_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_BITS + 2);

  logic [2:0] lvl;
  logic       sclk_d, latch_d;
  logic       sclk_rise, sclk_fall, latch_rise;
  logic [FRAME_BITS-1:0] word, load_word;
  logic [CNT_W-1:0]      cnt;
  logic       load, chain, rb_pend, sdo_raw;

  scif_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({latch_i, sdi_i, sclk_i}),
    .q_o   (lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d  <= 1'b0;
      latch_d <= 1'b0;
    end else begin
      sclk_d  <= lvl[0];
      latch_d <= lvl[2];
    end
  end

  assign sclk_rise  =  lvl[0] & ~sclk_d;
  assign sclk_fall  = ~lvl[0] &  sclk_d;
  assign latch_rise =  lvl[2] & ~latch_d;

  scif_shifter #(.FRAME_W(FRAME_BITS), .CNT_W(CNT_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_rise_i (sclk_rise),
    .sclk_fall_i (sclk_fall),
    .sdi_i       (lvl[1]),
    .latch_rise_i(latch_rise),
    .load_i      (load),
    .load_word_i (load_word),
    .word_o      (word),
    .cnt_o       (cnt),
    .sdo_o       (sdo_raw)
  );

  scif_regs #(.FRAME_W(FRAME_BITS), .DATA_W(WORD_BITS), .CNT_W(CNT_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .latch_rise_i(latch_rise),
    .word_i      (word),
    .cnt_i       (cnt),
    .data_o      (data_o),
    .ctrl_o      (ctrl_o),
    .wr_stb_o    (wr_stb_o),
    .err_o       (frame_err_o),
    .chain_o     (chain),
    .rb_pend_o   (rb_pend),
    .load_o      (load),
    .load_word_o (load_word)
  );

  // output is quiet unless chaining or a readback is armed
  assign sdo_o = sdo_raw & (chain | rb_pend);
endmodule

// File: tb/serial_cmd_if_bench.sv
module serial_cmd_if_bench;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sdi = 1'b0, latch = 1'b0;
  logic sdo;
  logic [15:0] data, ctrl;
  logic wr_stb, frame_err;

  int n_checks = 0, n_errors = 0, stb_cnt = 0, err_cnt = 0;
  logic [47:0] cap = '0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  serial_cmd_if u_serial_cmd_if (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdi_i(sdi), .latch_i(latch),
    .sdo_o(sdo), .data_o(data), .ctrl_o(ctrl), .wr_stb_o(wr_stb), .frame_err_o(frame_err)
  );

  always @(negedge clk) begin
    if (wr_stb)    stb_cnt <= stb_cnt + 1;
    if (frame_err) err_cnt <= err_cnt + 1;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [47:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = v[i];
      wait_clk(HALF);
      cap = {cap[46:0], sdo};
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(HALF);
  endtask

  task automatic latch_pulse();
    latch = 1'b1;
    wait_clk(2 * HALF);
    latch = 1'b0;
    wait_clk(4 * HALF);
  endtask

  task automatic frame(input logic [23:0] w);
    send({24'h0, w}, 24);
    latch_pulse();
  endtask

  task automatic t_reset();
    chk("R1 data", data, 0);
    chk("R1 ctrl", ctrl, 0);
    chk("R1 sdo", sdo, 0);
    chk("R1 strobes", stb_cnt + err_cnt, 0);
  endtask

  task automatic t_data_write();
    int s0 = stb_cnt, e0 = err_cnt;
    frame({8'h01, 16'hABCD});
    chk("R2 data", data, 16'hABCD);
    chk("R2 one strobe", stb_cnt - s0, 1);
    chk("R2 no error", err_cnt - e0, 0);
  endtask

  task automatic t_ctrl_write();
    int s0 = stb_cnt;
    frame({8'h55, 16'h0011});
    chk("R3 ctrl", ctrl, 16'h0011);
    chk("R3 one strobe", stb_cnt - s0, 1);
    chk("R8 sdo quiet", sdo, 0);
  endtask

  task automatic t_bad_count();
    int s0 = stb_cnt, e0 = err_cnt;
    send({24'h0, 8'h01, 16'h1111}, 23);
    latch_pulse();
    chk("R4 short err", err_cnt - e0, 1);
    chk("R4 short data kept", data, 16'hABCD);
    send({23'h0, 1'b1, 8'h01, 16'h2222}, 25);
    latch_pulse();
    chk("R4 long err", err_cnt - e0, 2);
    chk("R4 long data kept", data, 16'hABCD);
    chk("R4 no strobe", stb_cnt - s0, 0);
  endtask

  task automatic t_latch_high();
    send({24'h0, 8'h01, 16'h1357}, 24);
    latch = 1'b1;
    wait_clk(4 * HALF);
    chk("R5 first commit", data, 16'h1357);
    send({24'h0, 8'h01, 16'h2468}, 24);
    chk("R5 no commit while high", data, 16'h1357);
    latch = 1'b0;
    wait_clk(2 * HALF);
    latch_pulse();
    chk("R5 commit last bits", data, 16'h2468);
  endtask

  task automatic t_nop();
    int s0 = stb_cnt, e0 = err_cnt;
    frame({8'h00, 16'hFFFF});
    frame({8'h33, 16'hFFFF});
    chk("R6 data kept", data, 16'h2468);
    chk("R6 ctrl kept", ctrl, 16'h0011);
    chk("R6 no pulses", (stb_cnt - s0) + (err_cnt - e0), 0);
  endtask

  task automatic t_clear_cmd();
    int s0 = stb_cnt;
    frame({8'h56, 16'h0000});
    chk("R7 bit0 clear no effect", data, 16'h2468);
    chk("R7 no strobe", stb_cnt - s0, 0);
    frame({8'h56, 16'h0001});
    chk("R7 data cleared", data, 0);
    chk("R7 ctrl cleared", ctrl, 0);
    chk("R7 strobe", stb_cnt - s0, 1);
  endtask

  task automatic t_readback();
    frame({8'h01, 16'hC3A5});
    frame({8'h55, 16'h0022});
    frame({8'h02, 16'h0001});
    chk("R8 first bit", sdo, 0);
    frame({8'h00, 16'h0000});
    chk("R8 data word", cap[23:0], {6'b0, 2'b01, 16'hC3A5});
    chk("R8 disarmed", sdo, 0);
    frame({8'h02, 16'h0000});
    frame({8'h00, 16'h0000});
    chk("R8 status word", cap[23:0], {6'b0, 2'b00, 16'h0001});
    frame({8'h02, 16'h0002});
    frame({8'h00, 16'h0000});
    chk("R8 ctrl word", cap[23:0], {6'b0, 2'b10, 16'h0022});
  endtask

  task automatic t_chain();
    int e0;
    frame({8'h55, 16'h0008});
    chk("R3 chain bit", ctrl, 16'h0008);
    e0 = err_cnt;
    send({24'hA1B2C3, 8'h01, 16'h4321}, 48);
    latch_pulse();
    chk("R9 ripple out", cap[23:0], 24'hA1B2C3);
    chk("R9 data", data, 16'h4321);
    chk("R9 long frame ok", err_cnt - e0, 0);
    send({28'h0, 20'h12345}, 20);
    latch_pulse();
    chk("R9 short err", err_cnt - e0, 1);
    chk("R9 data kept", data, 16'h4321);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(10);
    t_reset();
    t_data_write();
    t_ctrl_write();
    t_bad_count();
    t_latch_high();
    t_nop();
    t_clear_cmd();
    t_readback();
    t_chain();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule